// File: doc/BRIEF.md
# DMA Page Register and Address Former

This block holds the page bytes of a four-channel DMA group and turns a channel's current 16-bit address into a 31-bit physical start address for a transfer. Software reaches the page bytes through an eight-slot port window. Only four of the slots reach a channel, and the slot-to-channel map is deliberately not in order. There are two banks behind the same window. The low-page bank is always present. The high-page bank is present only while a strap input enables it.

A transfer engine asks for an address by presenting the channel number, the channel's current address, the position within the transfer, the transfer length and the channel's direction flag. One clock later the block answers with a valid pulse and the physical start address. In the upward direction the start is the paged base plus the position. In the downward direction the start is the paged base minus the position minus the length. The memory access and any reordering of data bytes are done elsewhere.

Top module: `xpage_unit`

## Requirements
- R1: After a synchronous reset, every low and high page byte reads as zero and `rsp_valid` is low.
- R2: The window offset selects the channel as follows: offset 7 selects channel 0, offset 3 selects channel 1, offset 1 selects channel 2 and offset 2 selects channel 3. A write with `p_bank`=0 stores `p_wdata` in the low byte of that channel, and `p_rdata` returns it.
- R3: Offsets 0, 4, 5 and 6 reach no channel. Writes to them change no byte, and reads from them return zero in both banks.
- R4: `p_bank`=1 selects the high-page bank, which uses the same offset map as R2. While `hi_en` is low, writes to that bank are dropped and reads from it return zero. Bytes stored earlier are kept.
- R5: The physical base is formed as follows: bits 30:24 hold bits 6:0 of the channel's high byte, bits 23:16 hold the low byte, and bits 15:0 hold `req_cur`. Bit 7 of the high byte is not used.
- R6: With `req_down`=0, `rsp_addr` is the base plus `req_pos`, taken modulo 2^31.
- R7: With `req_down`=1, `rsp_addr` is the base minus `req_pos` minus `req_len`, taken modulo 2^31.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_addr` keeps its value when no request is made.
- R9: While `hi_en` is low, the high-page field of the formed address is zero, whatever the stored high byte holds.
- R10: A request made in the same cycle as a page write uses the page value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_en | input | 1 | Strap that makes the high-page bank present |
| pw_en | input | 1 | Port write strobe |
| p_bank | input | 1 | Bank select: 0 selects the low page, 1 selects the high page |
| p_off | input | 3 | Offset within the port window |
| p_wdata | input | 8 | Port write data |
| p_rdata | output | 8 | Port read data, combinational from `p_bank` and `p_off` |
| req_valid | input | 1 | Address request strobe |
| req_chan | input | 2 | Channel whose page bytes are used |
| req_down | input | 1 | Channel direction flag (1 selects the downward direction) |
| req_cur | input | 16 | Channel's current address |
| req_pos | input | 16 | Position within the transfer |
| req_len | input | 16 | Transfer length |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_addr | output | 31 | Physical start address |

## Verification
The assertions check on every cycle the one-cycle response timing and the holding of the address, the zero read-back from unmapped offsets and from the absent high bank, and, for requests at position zero, that the low 16 address bits carry the current address and that the high field is cleared while the high bank is off. The full offset-to-channel map, the modulo arithmetic in both directions, the wrap-around at zero and at the top of the 31-bit space, and the old-value ordering when a write and a request share a cycle are shown only by the bench's sweeps. The bench compares each of these against addresses it computes itself.

// File: rtl/xpage_pkg.sv
// Package: shared constants, the slot type and the offset-to-channel map.
// Assumes a window of eight offsets of which four reach a channel.
package xpage_pkg;
    localparam int CHAN_N = 4;
    localparam int CHAN_W = 2;
    localparam int OFF_W  = 3;
    localparam int BYTE_W = 8;
    localparam int HI_USE = 7;
    localparam int CUR_W  = 16;

    typedef struct packed {
        logic              hit;
        logic [CHAN_W-1:0] chan;
    } slot_t;

    // Map a window offset to a channel; the holes return hit = 0.
    function automatic slot_t slot_of(input logic [OFF_W-1:0] off);
        slot_t s;
        s.hit  = 1'b1;
        s.chan = '0;
        case (off)
            3'd7:    s.chan = 2'd0;
            3'd3:    s.chan = 2'd1;
            3'd1:    s.chan = 2'd2;
            3'd2:    s.chan = 2'd3;
            default: s.hit  = 1'b0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/xpage_bank.sv
// Module: one bank of per-channel page bytes.
// Provides one read port for the window and one tap for the address former.
// Assumes N == 2**CW.
module xpage_bank #(
    parameter int N     = 4,
    parameter int CW    = 2,
    parameter int DW    = 8,
    parameter int TAP_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_chan,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] rd_chan,
    output logic [DW-1:0] rd_data,
    input  logic [CW-1:0] tap_chan,
    output logic [TAP_W-1:0] tap_data
);
    localparam int FLAT_W = N * DW;

    logic [FLAT_W-1:0] flat;

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [DW-1:0] q;
        // Hold the page byte of channel g; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_chan == CW'(g)))
                q <= wr_data;
        end
        assign flat[g*DW +: DW] = q;
    end

    // Window read mux.
    assign rd_data = flat[rd_chan*DW +: DW];

    // Address tap: only the bits the address uses.
    logic [DW-1:0] tap_full;
    assign tap_full = flat[tap_chan*DW +: DW];
    assign tap_data = tap_full[TAP_W-1:0];
endmodule

// File: rtl/xpage_port.sv
// Module: port window decoder.
// Turns bank and offset into per-bank write enables and a channel, and gates the read data.
// Assumes the high bank is absent while hi_en is low.
module xpage_port #(
    parameter int CW = 2,
    parameter int OW = 3,
    parameter int DW = 8
) (
    input  logic          pw_en,
    input  logic          p_bank,
    input  logic [OW-1:0] p_off,
    input  logic          hi_en,
    input  logic [DW-1:0] lo_rd,
    input  logic [DW-1:0] hi_rd,
    output logic          lo_we,
    output logic          hi_we,
    output logic [CW-1:0] chan,
    output logic [DW-1:0] p_rdata
);
    import xpage_pkg::*;

    slot_t slot;
    logic  present;

    // Decode the offset and whether the addressed bank answers.
    always_comb begin
        slot    = slot_of(p_off);
        chan    = slot.chan;
        present = slot.hit && (!p_bank || hi_en);
    end

    // Steer the write strobe to the addressed bank.
    always_comb begin
        lo_we = pw_en && present && !p_bank;
        hi_we = pw_en && present &&  p_bank;
    end

    // Return the selected byte, or zero for holes and an absent bank.
    always_comb begin
        if (!present)
            p_rdata = '0;
        else if (p_bank)
            p_rdata = hi_rd;
        else
            p_rdata = lo_rd;
    end
endmodule

// File: rtl/xpage_former.sv
// Module: registered physical address former.
// Concatenates the high page, the low page and the current address, then adds the position
// or subtracts the position and the length. Arithmetic wraps at the width of the result.
module xpage_former #(
    parameter int HW = 7,
    parameter int LW = 8,
    parameter int CUR_W = 16,
    parameter int POS_W = 16,
    parameter int LEN_W = 16,
    localparam int PHYS_W = HW + LW + CUR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_down,
    input  logic [HW-1:0]     hi_page,
    input  logic [LW-1:0]     lo_page,
    input  logic [CUR_W-1:0]  cur,
    input  logic [POS_W-1:0]  pos,
    input  logic [LEN_W-1:0]  len,
    output logic              rsp_valid,
    output logic [PHYS_W-1:0] rsp_addr
);
    logic [PHYS_W-1:0] base;
    logic [PHYS_W-1:0] pos_x;
    logic [PHYS_W-1:0] len_x;
    logic [PHYS_W-1:0] start;

    // Form the paged base and the start address for either direction.
    always_comb begin
        base  = {hi_page, lo_page, cur};
        pos_x = PHYS_W'(pos);
        len_x = PHYS_W'(len);
        if (req_down)
            start = base - pos_x - len_x;
        else
            start = base + pos_x;
    end

    // Register the response; the address holds between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid)
                rsp_addr <= start;
        end
    end
endmodule

// File: rtl/xpage_unit.sv
// Module: top of the DMA page register and address former.
// Two page banks behind one window, plus a registered address former. The high
// bank and its part of the address are gated by the hi_en strap.
module xpage_unit #(
    parameter int CHAN_N = xpage_pkg::CHAN_N,
    parameter int CHAN_W = xpage_pkg::CHAN_W,
    parameter int OFF_W  = xpage_pkg::OFF_W,
    parameter int BYTE_W = xpage_pkg::BYTE_W,
    parameter int HI_USE = xpage_pkg::HI_USE,
    parameter int CUR_W  = xpage_pkg::CUR_W,
    parameter int POS_W  = 16,
    parameter int LEN_W  = 16,
    localparam int PHYS_W = HI_USE + BYTE_W + CUR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_en,
    input  logic              pw_en,
    input  logic              p_bank,
    input  logic [OFF_W-1:0]  p_off,
    input  logic [BYTE_W-1:0] p_wdata,
    output logic [BYTE_W-1:0] p_rdata,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              req_down,
    input  logic [CUR_W-1:0]  req_cur,
    input  logic [POS_W-1:0]  req_pos,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_valid,
    output logic [PHYS_W-1:0] rsp_addr
);
    logic              lo_we, hi_we;
    logic [CHAN_W-1:0] win_chan;
    logic [BYTE_W-1:0] lo_rd, hi_rd;
    logic [BYTE_W-1:0] lo_tap;
    logic [HI_USE-1:0] hi_tap;
    logic [HI_USE-1:0] hi_eff;

    xpage_port #(.CW(CHAN_W), .OW(OFF_W), .DW(BYTE_W)) port_i (
        .pw_en(pw_en), .p_bank(p_bank), .p_off(p_off), .hi_en(hi_en),
        .lo_rd(lo_rd), .hi_rd(hi_rd), .lo_we(lo_we), .hi_we(hi_we),
        .chan(win_chan), .p_rdata(p_rdata)
    );

    xpage_bank #(.N(CHAN_N), .CW(CHAN_W), .DW(BYTE_W), .TAP_W(BYTE_W)) lo_bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(lo_we), .wr_chan(win_chan),
        .wr_data(p_wdata), .rd_chan(win_chan), .rd_data(lo_rd),
        .tap_chan(req_chan), .tap_data(lo_tap)
    );

    xpage_bank #(.N(CHAN_N), .CW(CHAN_W), .DW(BYTE_W), .TAP_W(HI_USE)) hi_bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(hi_we), .wr_chan(win_chan),
        .wr_data(p_wdata), .rd_chan(win_chan), .rd_data(hi_rd),
        .tap_chan(req_chan), .tap_data(hi_tap)
    );

    // The high page contributes only while its bank is present.
    assign hi_eff = hi_en ? hi_tap : '0;

    xpage_former #(.HW(HI_USE), .LW(BYTE_W), .CUR_W(CUR_W), .POS_W(POS_W), .LEN_W(LEN_W)) former_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_down(req_down),
        .hi_page(hi_eff), .lo_page(lo_tap), .cur(req_cur), .pos(req_pos), .len(req_len),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
    );
endmodule

// File: rtl/xpage_chk.sv
// Module: checker for xpage_unit, attached by bind. Observes ports only.
module xpage_chk #(
    parameter int OFF_W  = 3,
    parameter int BYTE_W = 8,
    parameter int HI_USE = 7,
    parameter int CUR_W  = 16,
    parameter int POS_W  = 16,
    parameter int LEN_W  = 16,
    parameter int PHYS_W = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hi_en,
    input logic              p_bank,
    input logic [OFF_W-1:0]  p_off,
    input logic [BYTE_W-1:0] p_rdata,
    input logic              req_valid,
    input logic              req_down,
    input logic [CUR_W-1:0]  req_cur,
    input logic [POS_W-1:0]  req_pos,
    input logic [LEN_W-1:0]  req_len,
    input logic              rsp_valid,
    input logic [PHYS_W-1:0] rsp_addr
);
    // R8
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R8
    no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_addr));
    // R3
    hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_off == 3'd0 || p_off == 3'd4 || p_off == 3'd5 || p_off == 3'd6) |-> (p_rdata == '0));
    // R4
    absent_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_bank && !hi_en) |-> (p_rdata == '0));
    // R5
    low_field_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_down && req_pos == '0) |=> (rsp_addr[CUR_W-1:0] == $past(req_cur)));
    // R7
    low_field_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_down && req_pos == '0 && req_len == '0) |=> (rsp_addr[CUR_W-1:0] == $past(req_cur)));
    // R9
    hi_field_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hi_en && !req_down && req_pos == '0) |=> (rsp_addr[PHYS_W-1 -: HI_USE] == '0));
endmodule

bind xpage_unit xpage_chk #(
    .OFF_W(OFF_W), .BYTE_W(BYTE_W), .HI_USE(HI_USE), .CUR_W(CUR_W),
    .POS_W(POS_W), .LEN_W(LEN_W), .PHYS_W(PHYS_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .p_bank(p_bank), .p_off(p_off),
    .p_rdata(p_rdata), .req_valid(req_valid), .req_down(req_down), .req_cur(req_cur),
    .req_pos(req_pos), .req_len(req_len), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
);

// File: tb/xpage_unit_tb.sv
// Bench: sweeps the whole port window in both banks with the strap in both states,
// then checks addresses against arithmetic done here.
module xpage_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hi_en = 1'b0;
    logic        pw_en = 1'b0;
    logic        p_bank = 1'b0;
    logic [2:0]  p_off = '0;
    logic [7:0]  p_wdata = '0;
    logic [7:0]  p_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic        req_down = 1'b0;
    logic [15:0] req_cur = '0;
    logic [15:0] req_pos = '0;
    logic [15:0] req_len = '0;
    logic        rsp_valid;
    logic [30:0] rsp_addr;

    int total = 0;
    int bad = 0;
    bit ended = 0;
    logic [7:0] lo_m [4];
    logic [7:0] hi_m [4];
    logic [31:0] seed = 32'h1F2E3D4C;

    always #10 clk = ~clk;

    xpage_unit dut_i (
        .clk(clk), .rst_n(rst_n), .hi_en(hi_en), .pw_en(pw_en), .p_bank(p_bank),
        .p_off(p_off), .p_wdata(p_wdata), .p_rdata(p_rdata), .req_valid(req_valid),
        .req_chan(req_chan), .req_down(req_down), .req_cur(req_cur), .req_pos(req_pos),
        .req_len(req_len), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr)
    );

    function automatic int chan_of(input int off);
        case (off)
            7: return 0;
            3: return 1;
            1: return 2;
            2: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [30:0] want_addr(input int ch, input logic dn,
            input logic [15:0] cur, input logic [15:0] pos, input logic [15:0] len,
            input logic en, input logic [7:0] lo, input logic [7:0] hi);
        logic [30:0] b;
        b = {(en ? hi[6:0] : 7'd0), lo, cur};
        if (dn) return b - 31'(pos) - 31'(len);
        return b + 31'(pos);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_rand(output logic [31:0] r);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        r = seed;
    endtask

    task automatic port_write(input logic bk, input int off, input logic [7:0] d);
        @(negedge clk);
        pw_en = 1'b1; p_bank = bk; p_off = 3'(off); p_wdata = d;
        @(negedge clk);
        pw_en = 1'b0;
    endtask

    task automatic port_read(input logic bk, input int off, output logic [7:0] d);
        p_bank = bk; p_off = 3'(off);
        #1;
        d = p_rdata;
    endtask

    task automatic request(input int ch, input logic dn, input logic [15:0] cur,
                           input logic [15:0] pos, input logic [15:0] len, input string req);
        logic [30:0] exp;
        logic [30:0] held;
        exp = want_addr(ch, dn, cur, pos, len, hi_en, lo_m[ch], hi_m[ch]);
        @(negedge clk);
        req_valid = 1'b1; req_chan = 2'(ch); req_down = dn;
        req_cur = cur; req_pos = pos; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({req, " addr"}, 32'(rsp_addr), 32'(exp));
        held = rsp_addr;
        @(negedge clk);
        // R8: idle cycle drops valid and holds the address
        check("R8 idle valid", 32'(rsp_valid), 32'd0);
        check("R8 idle hold", 32'(rsp_addr), 32'(held));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin lo_m[i] = '0; hi_m[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        hi_en = 1'b1;
        // R1: reset state
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        for (int b = 0; b < 2; b++)
            for (int o = 0; o < 8; o++) begin
                port_read(b[0], o, rd);
                check("R1 page zero", 32'(rd), 32'd0);
            end

        // R2 R3 R4: window sweep, strap in both states
        for (int e = 0; e < 2; e++) begin
            hi_en = e[0];
            for (int b = 0; b < 2; b++)
                for (int o = 0; o < 8; o++) begin
                    logic [7:0] d;
                    int ch;
                    d = 8'(8'hA5 ^ (o * 37) ^ (b << 6) ^ (e << 3) ^ 8'h80);
                    port_write(b[0], o, d);
                    ch = chan_of(o);
                    if (ch >= 0) begin
                        if (b == 0) lo_m[ch] = d;
                        else if (e == 1) hi_m[ch] = d;
                    end
                    for (int rb = 0; rb < 2; rb++)
                        for (int ro = 0; ro < 8; ro++) begin
                            int rc;
                            logic [7:0] exp;
                            rc = chan_of(ro);
                            if (rc < 0) exp = 8'h00;
                            else if (rb == 0) exp = lo_m[rc];
                            else if (e == 1) exp = hi_m[rc];
                            else exp = 8'h00;
                            port_read(rb[0], ro, rd);
                            if (rc < 0) check("R3 hole read", 32'(rd), 32'(exp));
                            else if (rb == 1) check("R4 high bank", 32'(rd), 32'(exp));
                            else check("R2 low map", 32'(rd), 32'(exp));
                        end
                end
        end

        // R5 R6 R7 R9: swept requests
        for (int i = 0; i < 400; i++) begin
            logic [15:0] cu, po, le;
            logic dn;
            int ch;
            if (i % 50 == 0) begin
                next_rand(r);
                hi_en = 1'b1;
                port_write(1'b0, 7, r[7:0]);   lo_m[0] = r[7:0];
                port_write(1'b1, 3, r[15:8]);  hi_m[1] = r[15:8];
                port_write(1'b1, 1, r[23:16]); hi_m[2] = r[23:16];
                port_write(1'b0, 2, r[31:24]); lo_m[3] = r[31:24];
            end
            next_rand(r);
            ch = int'(r[1:0]); dn = r[2]; hi_en = r[3];
            cu = r[31:16];
            next_rand(r);
            po = r[15:0]; le = r[31:16];
            if (i % 7 == 0) po = '0;
            if (dn) request(ch, dn, cu, po, le, hi_en ? "R7 down" : "R9 down strap off");
            else request(ch, dn, cu, po, le, hi_en ? "R6 up" : "R9 up strap off");
        end

        // R5: bit 7 of high byte unused; full field
        hi_en = 1'b1;
        port_write(1'b1, 7, 8'hFF); hi_m[0] = 8'hFF;
        port_write(1'b0, 7, 8'hFF); lo_m[0] = 8'hFF;
        request(0, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, "R5 full base");
        // R6: wrap above 2^31
        request(0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, "R6 wrap top");
        // R7: wrap below zero
        port_write(1'b1, 7, 8'h00); hi_m[0] = 8'h00;
        port_write(1'b0, 7, 8'h00); lo_m[0] = 8'h00;
        request(0, 1'b1, 16'h0000, 16'h0000, 16'h0001, "R7 wrap zero");

        // R10: write and request in the same cycle
        begin
            logic [30:0] exp_old;
            port_write(1'b0, 3, 8'h11); lo_m[1] = 8'h11;
            exp_old = want_addr(1, 1'b0, 16'h0100, 16'h0002, 16'h0000, hi_en, lo_m[1], hi_m[1]);
            @(negedge clk);
            pw_en = 1'b1; p_bank = 1'b0; p_off = 3'd3; p_wdata = 8'h5C;
            req_valid = 1'b1; req_chan = 2'd1; req_down = 1'b0;
            req_cur = 16'h0100; req_pos = 16'h0002; req_len = '0;
            @(negedge clk);
            pw_en = 1'b0; req_valid = 1'b0;
            lo_m[1] = 8'h5C;
            check("R10 old page used", 32'(rsp_addr), 32'(exp_old));
            request(1, 1'b0, 16'h0100, 16'h0002, 16'h0000, "R10 new page after");
        end

        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule